// File: doc/BRIEF.md
# Translation staging register updater

This block holds the staging fields that software and the hardware tablewalk use to describe one address translation entry. The fields are: array select, entry select, next-victim hint, valid, invalidate-protect, translation ID, address space, page size, effective and real page numbers, storage attributes, user attributes and permissions. When the translation machinery reports an event, the block reloads the fields in one step. An event is a translation miss on a fetch or a data access, a table search that hits, a table search that misses, an entry read or an entry write. Each field takes its new value from whichever source that event selects. The possible sources are configured defaults, the live PID and MSR state, the search operands, the addressed entry's contents, or zeros.

The block also owns the replacement hint of the small associative array. That hint is a next-victim counter. It supplies the entry select and its complement on misses, it is shown on reads and small-array hits, and it is reloaded from the staged hint when an entry is written into the small array. All updates land on the clock edge after the event strobe. Where a field has no defined source, it is driven to zero.

Top module: `xlat_stage_upd`

## Requirements
- R1: While `rst_n` is low, every output field reads zero and the next-victim counter is zero.
- R2: Event codes are 0 translation miss, 1 search hit, 2 search miss, 3 entry read and 4 entry write. At most one event is taken per cycle and its effects appear after the next rising edge. With `ev_valid` low, or with codes 5 to 7, no field and no counter changes.
- R3: The array select value 0 means the small array and 1 means the large array. A translation miss or a search miss loads array select from `dflt_arr_sel`. A search hit loads it from `hit_arr`. A read or a write leaves it unchanged.
- R4: On a translation miss or a search miss with `dflt_arr_sel` = 0, entry select takes the counter value (zero-extended) and the hint field takes its bitwise complement. With `dflt_arr_sel` = 1, both become zero.
- R5: A search hit loads entry select from `hit_idx`. On a search hit the hint field takes the counter if `hit_arr` = 0 and zero otherwise. A read loads the hint with the counter if the staged array select is 0 and zero otherwise, and leaves entry select unchanged.
- R6: Valid becomes 1 on a translation miss and on a search hit, 0 on a search miss, and `ent_valid` on a read.
- R7: Invalidate-protect becomes 0 on a translation miss and on a search miss. It takes `ent_prot` on a search hit in the large array, or on a read while the staged array select is 1. Otherwise it is 0.
- R8: The translation ID takes `pid_regs[dflt_tid_sel]` on a translation miss, `srch_pid` on a search miss, and `ent_tid` on a search hit or a read.
- R9: The address space takes `msr_is` on a miss with `ev_is_instr` = 1, `msr_ds` on a miss with `ev_is_instr` = 0, `srch_as` on a search miss, and `ent_as` on a search hit or a read.
- R10: Page size, storage attributes and user attributes take their default inputs on a translation miss or a search miss, and the entry's values on a search hit or a read.
- R11: The real page number and the permissions become zero on a translation miss or a search miss. They take the entry's values on a search hit or a read.
- R12: The effective page number takes `ev_epn` on a translation miss. It is unchanged on a search miss and takes `ent_epn` on a search hit or a read.
- R13: A write changes no output field. If the staged array select is 0, the counter loads the staged hint field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe |
| ev_kind | input | 3 | Event code |
| ev_is_instr | input | 1 | Miss came from an instruction fetch |
| ev_epn | input | EPN_W | Effective page number of the missing access |
| msr_is | input | 1 | Instruction address-space bit |
| msr_ds | input | 1 | Data address-space bit |
| pid_regs | input | NPID*PID_W | Process ID registers |
| dflt_arr_sel | input | 1 | Default array select |
| dflt_tid_sel | input | clog2(NPID) | Default PID register choice |
| dflt_size | input | SIZE_W | Default page size |
| dflt_attr | input | ATTR_W | Default storage attributes |
| dflt_uattr | input | UATTR_W | Default user attributes |
| srch_pid | input | PID_W | Search translation ID |
| srch_as | input | 1 | Search address space |
| ent_valid | input | 1 | Entry valid bit |
| ent_prot | input | 1 | Entry invalidate-protect bit |
| ent_tid | input | PID_W | Entry translation ID |
| ent_as | input | 1 | Entry address space |
| ent_size | input | SIZE_W | Entry page size |
| ent_epn | input | EPN_W | Entry effective page number |
| ent_attr | input | ATTR_W | Entry storage attributes |
| ent_uattr | input | UATTR_W | Entry user attributes |
| ent_rpn | input | RPN_W | Entry real page number |
| ent_perm | input | PERM_W | Entry permission and user bits |
| hit_arr | input | 1 | Array that hit on a search |
| hit_idx | input | ESEL_W | Index of the entry that hit |
| o_arr_sel | output | 1 | Staged array select |
| o_esel | output | ESEL_W | Staged entry select |
| o_nv | output | clog2(SMALL_WAYS) | Staged next-victim hint |
| o_valid | output | 1 | Staged valid |
| o_prot | output | 1 | Staged invalidate-protect |
| o_tid | output | PID_W | Staged translation ID |
| o_as | output | 1 | Staged address space |
| o_size | output | SIZE_W | Staged page size |
| o_epn | output | EPN_W | Staged effective page number |
| o_attr | output | ATTR_W | Staged storage attributes |
| o_uattr | output | UATTR_W | Staged user attributes |
| o_rpn | output | RPN_W | Staged real page number |
| o_perm | output | PERM_W | Staged permission bits |

## Verification
A wrong source selection shows up one cycle after the event, because every field register is visible at the ports. A corrupted field that should have held shows at the very next comparison after an idle or write cycle. A wrong next-victim counter is hidden until the next miss with a small-array default, or the next read or small-array hit. Its first sign is then a wrong entry select or hint one cycle after that event. The stimulus therefore interleaves writes with misses, so that a bad counter load is exposed within a few events.

// File: rtl/xsu_pkg.sv
package xsu_pkg;
   localparam logic [2:0] EV_XLAT_MISS = 3'd0;
   localparam logic [2:0] EV_SRCH_HIT  = 3'd1;
   localparam logic [2:0] EV_SRCH_MISS = 3'd2;
   localparam logic [2:0] EV_READ      = 3'd3;
   localparam logic [2:0] EV_WRITE     = 3'd4;

   localparam logic ARR_SMALL = 1'b0;
   localparam logic ARR_LARGE = 1'b1;

   function automatic int width_of(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/xsu_pid_pick.sv
module xsu_pid_pick #(
   parameter int NPID  = 4,
   parameter int PID_W = 8,
   localparam int TSW  = xsu_pkg::width_of(NPID)
) (
   input  logic [NPID-1:0][PID_W-1:0] pids,
   input  logic [TSW-1:0]             sel,
   output logic [PID_W-1:0]           pid_o
);
   logic [NPID-1:0][PID_W-1:0] masked;

   for (genvar i = 0; i < NPID; i++) begin : g_pid
      assign masked[i] = (sel == TSW'(i)) ? pids[i] : '0;
   end

   always_comb begin
      pid_o = '0;
      for (int k = 0; k < NPID; k++) pid_o = pid_o | masked[k];
   end
endmodule

// File: rtl/xsu_victim.sv
module xsu_victim #(
   parameter int VW = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [VW-1:0] ld_val,
   output logic [VW-1:0] vict
);
   always_ff @(posedge clk) begin
      if (!rst_n)  vict <= '0;
      else if (ld) vict <= ld_val;
   end
endmodule

// File: rtl/xsu_next.sv
module xsu_next #(
   parameter int EPN_W   = 20,
   parameter int RPN_W   = 24,
   parameter int PID_W   = 8,
   parameter int SIZE_W  = 4,
   parameter int ATTR_W  = 5,
   parameter int UATTR_W = 2,
   parameter int PERM_W  = 10,
   parameter int ESEL_W  = 4,
   parameter int VW      = 1
) (
   input  logic               ev_valid,
   input  logic [2:0]         ev_kind,
   input  logic               ev_is_instr,
   input  logic [EPN_W-1:0]   ev_epn,
   input  logic               msr_is,
   input  logic               msr_ds,
   input  logic [PID_W-1:0]   dflt_pid,
   input  logic               dflt_arr_sel,
   input  logic [SIZE_W-1:0]  dflt_size,
   input  logic [ATTR_W-1:0]  dflt_attr,
   input  logic [UATTR_W-1:0] dflt_uattr,
   input  logic [PID_W-1:0]   srch_pid,
   input  logic               srch_as,
   input  logic               ent_valid,
   input  logic               ent_prot,
   input  logic [PID_W-1:0]   ent_tid,
   input  logic               ent_as,
   input  logic [SIZE_W-1:0]  ent_size,
   input  logic [EPN_W-1:0]   ent_epn,
   input  logic [ATTR_W-1:0]  ent_attr,
   input  logic [UATTR_W-1:0] ent_uattr,
   input  logic [RPN_W-1:0]   ent_rpn,
   input  logic [PERM_W-1:0]  ent_perm,
   input  logic               hit_arr,
   input  logic [ESEL_W-1:0]  hit_idx,
   input  logic [VW-1:0]      vict,
   input  logic               c_sel,
   input  logic [ESEL_W-1:0]  c_esel,
   input  logic [VW-1:0]      c_nv,
   input  logic               c_valid,
   input  logic               c_prot,
   input  logic [PID_W-1:0]   c_tid,
   input  logic               c_as,
   input  logic [SIZE_W-1:0]  c_size,
   input  logic [EPN_W-1:0]   c_epn,
   input  logic [ATTR_W-1:0]  c_attr,
   input  logic [UATTR_W-1:0] c_uattr,
   input  logic [RPN_W-1:0]   c_rpn,
   input  logic [PERM_W-1:0]  c_perm,
   output logic               n_sel,
   output logic [ESEL_W-1:0]  n_esel,
   output logic [VW-1:0]      n_nv,
   output logic               n_valid,
   output logic               n_prot,
   output logic [PID_W-1:0]   n_tid,
   output logic               n_as,
   output logic [SIZE_W-1:0]  n_size,
   output logic [EPN_W-1:0]   n_epn,
   output logic [ATTR_W-1:0]  n_attr,
   output logic [UATTR_W-1:0] n_uattr,
   output logic [RPN_W-1:0]   n_rpn,
   output logic [PERM_W-1:0]  n_perm
);
   import xsu_pkg::*;

   logic [ESEL_W-1:0] vict_ext;

   if (ESEL_W > VW) begin : g_ext_pad
      assign vict_ext = {{(ESEL_W-VW){1'b0}}, vict};
   end else begin : g_ext_same
      assign vict_ext = vict;
   end

   logic dflt_small;
   assign dflt_small = (dflt_arr_sel == ARR_SMALL);

   always_comb begin
      n_sel   = c_sel;
      n_esel  = c_esel;
      n_nv    = c_nv;
      n_valid = c_valid;
      n_prot  = c_prot;
      n_tid   = c_tid;
      n_as    = c_as;
      n_size  = c_size;
      n_epn   = c_epn;
      n_attr  = c_attr;
      n_uattr = c_uattr;
      n_rpn   = c_rpn;
      n_perm  = c_perm;
      if (ev_valid) begin
         case (ev_kind)
            EV_XLAT_MISS, EV_SRCH_MISS: begin
               n_sel   = dflt_arr_sel;
               n_esel  = dflt_small ? vict_ext : '0;
               n_nv    = dflt_small ? ~vict : '0;
               n_prot  = 1'b0;
               n_size  = dflt_size;
               n_attr  = dflt_attr;
               n_uattr = dflt_uattr;
               n_rpn   = '0;
               n_perm  = '0;
               if (ev_kind == EV_XLAT_MISS) begin
                  n_valid = 1'b1;
                  n_tid   = dflt_pid;
                  n_as    = ev_is_instr ? msr_is : msr_ds;
                  n_epn   = ev_epn;
               end else begin
                  n_valid = 1'b0;
                  n_tid   = srch_pid;
                  n_as    = srch_as;
               end
            end
            EV_SRCH_HIT, EV_READ: begin
               n_tid   = ent_tid;
               n_as    = ent_as;
               n_size  = ent_size;
               n_epn   = ent_epn;
               n_attr  = ent_attr;
               n_uattr = ent_uattr;
               n_rpn   = ent_rpn;
               n_perm  = ent_perm;
               if (ev_kind == EV_SRCH_HIT) begin
                  n_sel   = hit_arr;
                  n_esel  = hit_idx;
                  n_nv    = (hit_arr == ARR_SMALL) ? vict : '0;
                  n_valid = 1'b1;
                  n_prot  = (hit_arr == ARR_LARGE) ? ent_prot : 1'b0;
               end else begin
                  n_nv    = (c_sel == ARR_SMALL) ? vict : '0;
                  n_valid = ent_valid;
                  n_prot  = (c_sel == ARR_LARGE) ? ent_prot : 1'b0;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/xlat_stage_upd.sv
module xlat_stage_upd #(
   parameter int EPN_W        = 20,
   parameter int RPN_W        = 24,
   parameter int PID_W        = 8,
   parameter int NPID         = 4,
   parameter int SIZE_W       = 4,
   parameter int ATTR_W       = 5,
   parameter int UATTR_W      = 2,
   parameter int PERM_W       = 10,
   parameter int SMALL_WAYS   = 2,
   parameter int LARGE_ENTRIES = 16,
   localparam int TSW    = xsu_pkg::width_of(NPID),
   localparam int VW     = xsu_pkg::width_of(SMALL_WAYS),
   localparam int LIW    = xsu_pkg::width_of(LARGE_ENTRIES),
   localparam int ESEL_W = (LIW > VW) ? LIW : VW
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ev_valid,
   input  logic [2:0]                  ev_kind,
   input  logic                        ev_is_instr,
   input  logic [EPN_W-1:0]            ev_epn,
   input  logic                        msr_is,
   input  logic                        msr_ds,
   input  logic [NPID-1:0][PID_W-1:0]  pid_regs,
   input  logic                        dflt_arr_sel,
   input  logic [TSW-1:0]              dflt_tid_sel,
   input  logic [SIZE_W-1:0]           dflt_size,
   input  logic [ATTR_W-1:0]           dflt_attr,
   input  logic [UATTR_W-1:0]          dflt_uattr,
   input  logic [PID_W-1:0]            srch_pid,
   input  logic                        srch_as,
   input  logic                        ent_valid,
   input  logic                        ent_prot,
   input  logic [PID_W-1:0]            ent_tid,
   input  logic                        ent_as,
   input  logic [SIZE_W-1:0]           ent_size,
   input  logic [EPN_W-1:0]            ent_epn,
   input  logic [ATTR_W-1:0]           ent_attr,
   input  logic [UATTR_W-1:0]          ent_uattr,
   input  logic [RPN_W-1:0]            ent_rpn,
   input  logic [PERM_W-1:0]           ent_perm,
   input  logic                        hit_arr,
   input  logic [ESEL_W-1:0]           hit_idx,
   output logic                        o_arr_sel,
   output logic [ESEL_W-1:0]           o_esel,
   output logic [VW-1:0]               o_nv,
   output logic                        o_valid,
   output logic                        o_prot,
   output logic [PID_W-1:0]            o_tid,
   output logic                        o_as,
   output logic [SIZE_W-1:0]           o_size,
   output logic [EPN_W-1:0]            o_epn,
   output logic [ATTR_W-1:0]           o_attr,
   output logic [UATTR_W-1:0]          o_uattr,
   output logic [RPN_W-1:0]            o_rpn,
   output logic [PERM_W-1:0]           o_perm
);
   import xsu_pkg::*;

   initial begin
      assert (NPID >= 2) else $error("NPID must be at least 2");
      assert (SMALL_WAYS >= 2 && (SMALL_WAYS & (SMALL_WAYS - 1)) == 0)
         else $error("SMALL_WAYS must be a power of two, at least 2");
      assert (LARGE_ENTRIES >= 2) else $error("LARGE_ENTRIES must be at least 2");
      assert (EPN_W > 0 && RPN_W > 0 && PID_W > 0 && SIZE_W > 0 &&
              ATTR_W > 0 && UATTR_W > 0 && PERM_W > 0)
         else $error("field widths must be positive");
   end

   logic [PID_W-1:0]   dflt_pid;
   logic [VW-1:0]      vict;
   logic               vict_ld;
   logic               n_sel, n_valid, n_prot, n_as;
   logic [ESEL_W-1:0]  n_esel;
   logic [VW-1:0]      n_nv;
   logic [PID_W-1:0]   n_tid;
   logic [SIZE_W-1:0]  n_size;
   logic [EPN_W-1:0]   n_epn;
   logic [ATTR_W-1:0]  n_attr;
   logic [UATTR_W-1:0] n_uattr;
   logic [RPN_W-1:0]   n_rpn;
   logic [PERM_W-1:0]  n_perm;

   xsu_pid_pick #(.NPID(NPID), .PID_W(PID_W)) u_pick (
      .pids(pid_regs), .sel(dflt_tid_sel), .pid_o(dflt_pid)
   );

   assign vict_ld = ev_valid && (ev_kind == EV_WRITE) && (o_arr_sel == ARR_SMALL);

   xsu_victim #(.VW(VW)) u_vict (
      .clk(clk), .rst_n(rst_n), .ld(vict_ld), .ld_val(o_nv), .vict(vict)
   );

   xsu_next #(
      .EPN_W(EPN_W), .RPN_W(RPN_W), .PID_W(PID_W), .SIZE_W(SIZE_W),
      .ATTR_W(ATTR_W), .UATTR_W(UATTR_W), .PERM_W(PERM_W),
      .ESEL_W(ESEL_W), .VW(VW)
   ) u_next (
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_is_instr(ev_is_instr),
      .ev_epn(ev_epn), .msr_is(msr_is), .msr_ds(msr_ds), .dflt_pid(dflt_pid),
      .dflt_arr_sel(dflt_arr_sel), .dflt_size(dflt_size), .dflt_attr(dflt_attr),
      .dflt_uattr(dflt_uattr), .srch_pid(srch_pid), .srch_as(srch_as),
      .ent_valid(ent_valid), .ent_prot(ent_prot), .ent_tid(ent_tid),
      .ent_as(ent_as), .ent_size(ent_size), .ent_epn(ent_epn),
      .ent_attr(ent_attr), .ent_uattr(ent_uattr), .ent_rpn(ent_rpn),
      .ent_perm(ent_perm), .hit_arr(hit_arr), .hit_idx(hit_idx), .vict(vict),
      .c_sel(o_arr_sel), .c_esel(o_esel), .c_nv(o_nv), .c_valid(o_valid),
      .c_prot(o_prot), .c_tid(o_tid), .c_as(o_as), .c_size(o_size),
      .c_epn(o_epn), .c_attr(o_attr), .c_uattr(o_uattr), .c_rpn(o_rpn),
      .c_perm(o_perm),
      .n_sel(n_sel), .n_esel(n_esel), .n_nv(n_nv), .n_valid(n_valid),
      .n_prot(n_prot), .n_tid(n_tid), .n_as(n_as), .n_size(n_size),
      .n_epn(n_epn), .n_attr(n_attr), .n_uattr(n_uattr), .n_rpn(n_rpn),
      .n_perm(n_perm)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_arr_sel <= 1'b0;
         o_esel    <= '0;
         o_nv      <= '0;
         o_valid   <= 1'b0;
         o_prot    <= 1'b0;
         o_tid     <= '0;
         o_as      <= 1'b0;
         o_size    <= '0;
         o_epn     <= '0;
         o_attr    <= '0;
         o_uattr   <= '0;
         o_rpn     <= '0;
         o_perm    <= '0;
      end else begin
         o_arr_sel <= n_sel;
         o_esel    <= n_esel;
         o_nv      <= n_nv;
         o_valid   <= n_valid;
         o_prot    <= n_prot;
         o_tid     <= n_tid;
         o_as      <= n_as;
         o_size    <= n_size;
         o_epn     <= n_epn;
         o_attr    <= n_attr;
         o_uattr   <= n_uattr;
         o_rpn     <= n_rpn;
         o_perm    <= n_perm;
      end
   end

   // Held state: idle cycles and unused codes touch nothing
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid || ev_kind > EV_WRITE) |=>
         $stable(o_epn) && $stable(o_rpn) && $stable(o_tid) && $stable(o_esel) &&
         $stable(o_nv) && $stable(o_valid) && $stable(o_arr_sel));

   assert_write_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_WRITE) |=>
         $stable(o_epn) && $stable(o_rpn) && $stable(o_perm) && $stable(o_tid) &&
         $stable(o_esel) && $stable(o_nv) && $stable(o_valid) && $stable(o_prot));

   assert_miss_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_XLAT_MISS) |=> o_valid && !o_prot);

   assert_smiss_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_SRCH_MISS) |=> !o_valid && !o_prot);

   assert_miss_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && (ev_kind == EV_XLAT_MISS || ev_kind == EV_SRCH_MISS)) |=>
         (o_rpn == '0) && (o_perm == '0));

   assert_hit_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_SRCH_HIT) |=> o_esel == $past(hit_idx));

   assert_small_noprot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_SRCH_HIT && hit_arr == ARR_SMALL) |=> !o_prot);

   assert_large_dflt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && (ev_kind == EV_XLAT_MISS || ev_kind == EV_SRCH_MISS) &&
       dflt_arr_sel == ARR_LARGE) |=> (o_esel == '0) && (o_nv == '0) && o_arr_sel);

   assert_miss_epn_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == EV_XLAT_MISS) |=> o_epn == $past(ev_epn));
endmodule

// File: tb/xlat_stage_upd_bench.sv
module xlat_stage_upd_bench;
   localparam int EPN_W = 20, RPN_W = 24, PID_W = 8, NPID = 4, SIZE_W = 4;
   localparam int ATTR_W = 5, UATTR_W = 2, PERM_W = 10;
   localparam int TSW = 2, VW = 1, ESEL_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                       ev_valid, ev_is_instr, msr_is, msr_ds;
   logic [2:0]                 ev_kind;
   logic [EPN_W-1:0]           ev_epn, ent_epn;
   logic [NPID-1:0][PID_W-1:0] pid_regs;
   logic                       dflt_arr_sel, srch_as, ent_valid, ent_prot, ent_as, hit_arr;
   logic [TSW-1:0]             dflt_tid_sel;
   logic [SIZE_W-1:0]          dflt_size, ent_size;
   logic [ATTR_W-1:0]          dflt_attr, ent_attr;
   logic [UATTR_W-1:0]         dflt_uattr, ent_uattr;
   logic [PID_W-1:0]           srch_pid, ent_tid;
   logic [RPN_W-1:0]           ent_rpn;
   logic [PERM_W-1:0]          ent_perm;
   logic [ESEL_W-1:0]          hit_idx;

   logic                o_arr_sel, o_valid, o_prot, o_as;
   logic [ESEL_W-1:0]   o_esel;
   logic [VW-1:0]       o_nv;
   logic [PID_W-1:0]    o_tid;
   logic [SIZE_W-1:0]   o_size;
   logic [EPN_W-1:0]    o_epn;
   logic [ATTR_W-1:0]   o_attr;
   logic [UATTR_W-1:0]  o_uattr;
   logic [RPN_W-1:0]    o_rpn;
   logic [PERM_W-1:0]   o_perm;

   xlat_stage_upd u_xlat_stage_upd (.*);

   // expected state
   logic                m_sel, m_valid, m_prot, m_as;
   logic [ESEL_W-1:0]   m_esel;
   logic [VW-1:0]       m_nv, m_vict;
   logic [PID_W-1:0]    m_tid;
   logic [SIZE_W-1:0]   m_size;
   logic [EPN_W-1:0]    m_epn;
   logic [ATTR_W-1:0]   m_attr;
   logic [UATTR_W-1:0]  m_uattr;
   logic [RPN_W-1:0]    m_rpn;
   logic [PERM_W-1:0]   m_perm;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input string nm, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_sel = 0; m_valid = 0; m_prot = 0; m_as = 0; m_esel = '0; m_nv = '0;
      m_vict = '0; m_tid = '0; m_size = '0; m_epn = '0; m_attr = '0;
      m_uattr = '0; m_rpn = '0; m_perm = '0;
   endtask

   task automatic randomize_payload();
      ev_is_instr = 1'($urandom); ev_epn = EPN_W'($urandom);
      msr_is = 1'($urandom); msr_ds = 1'($urandom);
      for (int i = 0; i < NPID; i++) pid_regs[i] = PID_W'($urandom);
      dflt_arr_sel = 1'($urandom); dflt_tid_sel = TSW'($urandom);
      dflt_size = SIZE_W'($urandom); dflt_attr = ATTR_W'($urandom);
      dflt_uattr = UATTR_W'($urandom); srch_pid = PID_W'($urandom);
      srch_as = 1'($urandom); ent_valid = 1'($urandom); ent_prot = 1'($urandom);
      ent_tid = PID_W'($urandom); ent_as = 1'($urandom); ent_size = SIZE_W'($urandom);
      ent_epn = EPN_W'($urandom); ent_attr = ATTR_W'($urandom);
      ent_uattr = UATTR_W'($urandom); ent_rpn = RPN_W'($urandom);
      ent_perm = PERM_W'($urandom); hit_arr = 1'($urandom);
      hit_idx = ESEL_W'($urandom);
   endtask

   // expected update from the requirements, using the inputs now driven
   task automatic model_apply();
      if (!ev_valid) return;
      case (ev_kind)
         3'd0, 3'd2: begin // R3 R4 R10 R11
            m_sel = dflt_arr_sel;
            m_esel = (dflt_arr_sel == 1'b0) ? ESEL_W'(m_vict) : '0;
            m_nv = (dflt_arr_sel == 1'b0) ? ~m_vict : '0;
            m_prot = 0; m_size = dflt_size; m_attr = dflt_attr; m_uattr = dflt_uattr;
            m_rpn = '0; m_perm = '0;
            if (ev_kind == 3'd0) begin
               m_valid = 1; m_tid = pid_regs[dflt_tid_sel];
               m_as = ev_is_instr ? msr_is : msr_ds; m_epn = ev_epn;
            end else begin
               m_valid = 0; m_tid = srch_pid; m_as = srch_as;
            end
         end
         3'd1: begin // R5 search hit
            m_sel = hit_arr; m_esel = hit_idx;
            m_nv = (hit_arr == 1'b0) ? m_vict : '0;
            m_valid = 1; m_prot = hit_arr ? ent_prot : 1'b0;
            m_tid = ent_tid; m_as = ent_as; m_size = ent_size; m_epn = ent_epn;
            m_attr = ent_attr; m_uattr = ent_uattr; m_rpn = ent_rpn; m_perm = ent_perm;
         end
         3'd3: begin // R5 read
            m_nv = (m_sel == 1'b0) ? m_vict : '0;
            m_valid = ent_valid; m_prot = m_sel ? ent_prot : 1'b0;
            m_tid = ent_tid; m_as = ent_as; m_size = ent_size; m_epn = ent_epn;
            m_attr = ent_attr; m_uattr = ent_uattr; m_rpn = ent_rpn; m_perm = ent_perm;
         end
         3'd4: begin // R13
            if (m_sel == 1'b0) m_vict = m_nv;
         end
         default: ;
      endcase
   endtask

   task automatic compare_all(input logic [2:0] kind, input logic vld);
      string rs, rn;
      bit idle;
      idle = !vld || kind > 3'd4;
      rn = (kind == 3'd0 || kind == 3'd2) ? "R4" : "R5";
      rs = idle ? "R2" : (kind == 3'd4) ? "R13" : "";
      chk(rs != "" ? rs : "R3",  "arr_sel", 64'(o_arr_sel), 64'(m_sel));
      chk(rs != "" ? rs : rn,    "esel",    64'(o_esel),    64'(m_esel));
      chk(rs != "" ? rs : rn,    "nv",      64'(o_nv),      64'(m_nv));
      chk(rs != "" ? rs : "R6",  "valid",   64'(o_valid),   64'(m_valid));
      chk(rs != "" ? rs : "R7",  "prot",    64'(o_prot),    64'(m_prot));
      chk(rs != "" ? rs : "R8",  "tid",     64'(o_tid),     64'(m_tid));
      chk(rs != "" ? rs : "R9",  "as",      64'(o_as),      64'(m_as));
      chk(rs != "" ? rs : "R10", "size",    64'(o_size),    64'(m_size));
      chk(rs != "" ? rs : "R10", "attr",    64'(o_attr),    64'(m_attr));
      chk(rs != "" ? rs : "R10", "uattr",   64'(o_uattr),   64'(m_uattr));
      chk(rs != "" ? rs : "R11", "rpn",     64'(o_rpn),     64'(m_rpn));
      chk(rs != "" ? rs : "R11", "perm",    64'(o_perm),    64'(m_perm));
      chk(rs != "" ? rs : "R12", "epn",     64'(o_epn),     64'(m_epn));
   endtask

   // called just after a falling edge with inputs set
   task automatic step();
      logic [2:0] k;
      logic v;
      k = ev_kind; v = ev_valid;
      model_apply();
      @(negedge clk);
      compare_all(k, v);
   endtask

   task automatic ev(input logic v, input logic [2:0] k);
      randomize_payload();
      ev_valid = v; ev_kind = k;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      randomize_payload();
      ev_valid = 0; ev_kind = 3'd0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state, even with an event strobe asserted
      ev(1'b1, 3'd1);
      @(negedge clk);
      chk("R1", "arr_sel", 64'(o_arr_sel), 0); chk("R1", "esel", 64'(o_esel), 0);
      chk("R1", "valid", 64'(o_valid), 0);     chk("R1", "epn", 64'(o_epn), 0);
      chk("R1", "rpn", 64'(o_rpn), 0);         chk("R1", "tid", 64'(o_tid), 0);
      ev_valid = 0;
      rst_n = 1'b1;
      @(negedge clk);

      // R4: miss with small default, counter 0 -> esel 0, hint 1
      ev(1'b1, 3'd0); dflt_arr_sel = 0; step();
      chk("R4", "esel after miss", 64'(o_esel), 0);
      chk("R4", "nv after miss", 64'(o_nv), 1);
      // R13: write with small staged select loads counter from hint (1)
      ev(1'b1, 3'd4); step();
      // R4: next miss now sees counter 1
      ev(1'b1, 3'd2); dflt_arr_sel = 0; step();
      chk("R4", "esel uses loaded counter", 64'(o_esel), 1);
      chk("R4", "nv complement", 64'(o_nv), 0);
      // R4: large default zeros both
      ev(1'b1, 3'd0); dflt_arr_sel = 1; step();
      chk("R4", "esel large default", 64'(o_esel), 0);
      // R13: write with large staged select leaves counter; read in small shows it
      ev(1'b1, 3'd4); step();
      ev(1'b1, 3'd1); hit_arr = 0; hit_idx = 4'd1; step();
      chk("R5", "nv shows counter on small hit", 64'(o_nv), 1);
      // R7: large hit with protect set
      ev(1'b1, 3'd1); hit_arr = 1; ent_prot = 1; hit_idx = 4'd15; step();
      chk("R7", "prot on large hit", 64'(o_prot), 1);
      chk("R5", "esel max index", 64'(o_esel), 15);
      // R9: instruction vs data address space
      ev(1'b1, 3'd0); ev_is_instr = 1; msr_is = 1; msr_ds = 0; step();
      chk("R9", "as from instruction bit", 64'(o_as), 1);
      ev(1'b1, 3'd0); ev_is_instr = 0; msr_is = 1; msr_ds = 0; step();
      chk("R9", "as from data bit", 64'(o_as), 0);
      // R2: idle and unused codes
      ev(1'b0, 3'd0); step();
      ev(1'b1, 3'd5); step();
      ev(1'b1, 3'd7); step();

      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom_range(0, 9));
         case (r)
            0, 1:    ev(1'b1, 3'd0);
            2:       ev(1'b1, 3'd1);
            3:       ev(1'b1, 3'd2);
            4:       ev(1'b1, 3'd3);
            5, 6:    ev(1'b1, 3'd4);
            7:       ev(1'b0, 3'($urandom));
            default: ev(1'b1, 3'($urandom_range(5, 7)));
         endcase
         step();
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule